// File: doc/BRIEF.md
# Three-Phase Sine-Table Compare Sequencer

This block supplies the compare words for a three-phase sinusoidal PWM stage. A single stored table holds one full cycle of a unipolar sine wave, centred at one half and spanning zero to full scale. Each phase keeps its own position in that table. Every time the carrier time base reports its zero point, the block looks up one entry per phase. It scales each entry by the carrier period and a modulation depth, then presents the three new compare words together with a one-cycle update strobe. That strobe is meant to reach the shadow compare registers of the PWM channels well before the next zero point.

The modulating frequency is the carrier frequency divided by the table length. A 25 kHz carrier and the default 500 steps give a 50 Hz output. Setting the three start positions a third of the table apart gives the usual 120 degree spacing. The counter, the action qualifier and the dead-band logic sit outside this block.

Top module: `spwm_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every compare output equals `per_i` shifted right by one and `upd_o` is low.
- R2: Table entry i (0 to 499) is the unsigned 16-bit code round(32767.5 × (1 + sin(2πi/500))), clamped to 65535.
- R3: Each compare word is floor(P × M × E / 2^31), limited to P. Here P is the captured period, M is the captured modulation word (Q1.15, where 32768 means 1.0) and E is the phase's table entry.
- R4: A modulation input above 32768 is treated as exactly 32768.
- R5: Each accepted zero event advances every phase index by one. An index that has reached 500 or more is replaced by 0 before the lookup, so a start offset of 500 or above first reads entry 0.
- R6: Reset loads the three phase indices from `ofs_a_i`, `ofs_b_i` and `ofs_c_i`. The first accepted event reads exactly those entries, unless R5 applies.
- R7: `upd_o` is a one-cycle pulse. It is high in the sixth cycle after the clock edge that accepted `zero_evt`. All three compare outputs change only together with it.
- R8: A `zero_evt` that is high in either of the two cycles after an accepted one is ignored and does not advance any index.
- R9: `per_i` and `mod_i` are captured when an event is accepted. Changing them afterwards does not affect that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_evt | input | 1 | Carrier zero-point strobe |
| per_i | input | 16 | Carrier period value |
| mod_i | input | 16 | Modulation depth, unsigned Q1.15 |
| ofs_a_i | input | 9 | Start index of phase A, loaded in reset |
| ofs_b_i | input | 9 | Start index of phase B, loaded in reset |
| ofs_c_i | input | 9 | Start index of phase C, loaded in reset |
| cmp_a_o | output | 16 | Compare word of phase A |
| cmp_b_o | output | 16 | Compare word of phase B |
| cmp_c_o | output | 16 | Compare word of phase C |
| upd_o | output | 1 | One-cycle strobe marking new compare words |

## Verification
The bench steps one run of more than 500 events through the wrap point. A design that wrapped one step late, or that advanced after the lookup instead of checking first, would shift every later word by one table position. Start offsets of 500 and 499 test the wrap-before-lookup rule directly. A held zero strobe checks that only one advance happens: a design that re-accepted it would skip table entries. Modulation above unity and a period changed in mid-update show whether the block clamps and captures its operands. Without that, the words would exceed the period or mix two periods. Periods of 0 and 65535 test the scaling at both ends of its range.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned NPH = 3;

  // Unipolar sine code for one table slot, full scale = 2^ew - 1
  function automatic int sine_code(int i, int n, int ew);
    real full, ang, v;
    int  code;
    full = real'((1 << ew) - 1);
    ang  = 2.0 * 3.14159265358979 * real'(i) / real'(n);
    v    = (full / 2.0) * (1.0 + $sin(ang)) + 0.5;
    code = $rtoi(v);
    if (code > (1 << ew) - 1) code = (1 << ew) - 1;
    if (code < 0) code = 0;
    return code;
  endfunction
endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int N  = 500,
  parameter int AW = 9,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [EW-1:0] data
);
  logic [EW-1:0] mem [N];

  initial begin
    for (int i = 0; i < N; i++) mem[i] = EW'(spwm_pkg::sine_code(i, N, EW));
  end

  // synchronous read, block-RAM style
  always_ff @(posedge clk) begin
    if (rd_en) data <= mem[addr];
  end
endmodule

// File: rtl/spwm_scale.sv
module spwm_scale #(
  parameter int EW  = 16,
  parameter int MW  = 16,
  parameter int PW  = 16,
  parameter int TW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [TW-1:0] in_tag,
  input  logic [EW-1:0] entry,
  input  logic [MW-1:0] modw,
  input  logic [PW-1:0] per,
  output logic          out_vld,
  output logic [TW-1:0] out_tag,
  output logic [PW-1:0] out_val
);
  localparam int FRAC   = EW + MW - 1;
  localparam int P1W    = EW + MW;
  localparam int P2W    = P1W + PW;
  localparam int QW     = P2W - FRAC;

  logic [P1W-1:0] p1;
  logic [PW-1:0]  per1;
  logic [TW-1:0]  tag1;
  logic           v1;
  logic [P2W-1:0] p2;
  logic [QW-1:0]  q;

  always_comb begin
    p2 = p1 * {{P1W{1'b0}}, per1};
    q  = p2[P2W-1:FRAC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      v1      <= in_vld;
      out_vld <= v1;
    end
    p1      <= {{MW{1'b0}}, entry} * {{EW{1'b0}}, modw};
    per1    <= per;
    tag1    <= in_tag;
    out_tag <= tag1;
    out_val <= (q > {{(QW-PW){1'b0}}, per1}) ? per1 : q[PW-1:0];
  end
endmodule

// File: rtl/spwm_seq.sv
module spwm_seq #(
  parameter int N  = 500,
  parameter int PW = 16,
  parameter int MW = 16,
  parameter int EW = 16,
  parameter int IW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero_evt,
  input  logic [PW-1:0] per_i,
  input  logic [MW-1:0] mod_i,
  input  logic [IW-1:0] ofs_a_i,
  input  logic [IW-1:0] ofs_b_i,
  input  logic [IW-1:0] ofs_c_i,
  output logic [PW-1:0] cmp_a_o,
  output logic [PW-1:0] cmp_b_o,
  output logic [PW-1:0] cmp_c_o,
  output logic          upd_o
);
  import spwm_pkg::*;
  localparam int PHW = $clog2(NPH);
  localparam logic [MW-1:0] MOD_ONE = MW'(1) << (MW - 1);
  localparam logic [PHW-1:0] LAST_PH = PHW'(NPH - 1);

  logic [IW-1:0]  ofs [NPH];
  logic [IW-1:0]  idx [NPH];
  logic [PW-1:0]  cmp_q [NPH];
  logic [PW-1:0]  res [NPH-1];
  logic           iss_act;
  logic [PHW-1:0] iss_ph, cur_ph, tag_a, scl_tag;
  logic           accept, iss_go, v_a, scl_vld;
  logic [IW-1:0]  wrapped;
  logic [PW-1:0]  per_cap, scl_val;
  logic [MW-1:0]  mod_cap, mod_eff;
  logic [EW-1:0]  rom_data;

  assign ofs[0] = ofs_a_i;
  assign ofs[1] = ofs_b_i;
  assign ofs[2] = ofs_c_i;

  assign accept  = zero_evt && !iss_act && !rst;
  assign iss_go  = accept || iss_act;
  assign cur_ph  = accept ? '0 : iss_ph;
  assign wrapped = (idx[cur_ph] >= IW'(N)) ? '0 : idx[cur_ph];
  assign mod_eff = (mod_i > MOD_ONE) ? MOD_ONE : mod_i;

  // issue sequencer: one table read per phase on consecutive cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_act <= 1'b0;
      iss_ph  <= '0;
      per_cap <= per_i;
      mod_cap <= mod_eff;
      v_a     <= 1'b0;
    end else begin
      v_a <= iss_go;
      if (accept) begin
        iss_act <= 1'b1;
        iss_ph  <= PHW'(1);
        per_cap <= per_i;
        mod_cap <= mod_eff;
      end else if (iss_act) begin
        if (iss_ph == LAST_PH) begin
          iss_act <= 1'b0;
          iss_ph  <= '0;
        end else begin
          iss_ph <= iss_ph + PHW'(1);
        end
      end
    end
    tag_a <= cur_ph;
  end

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_idx
      always_ff @(posedge clk) begin
        if (rst)
          idx[p] <= ofs[p];
        else if (iss_go && cur_ph == PHW'(p))
          idx[p] <= wrapped + IW'(1);
      end
    end
  endgenerate

  spwm_sine_rom #(.N(N), .AW(IW), .EW(EW)) u_rom (
    .clk  (clk),
    .rd_en(iss_go),
    .addr (wrapped),
    .data (rom_data)
  );

  spwm_scale #(.EW(EW), .MW(MW), .PW(PW), .TW(PHW)) u_scale (
    .clk    (clk),
    .rst    (rst),
    .in_vld (v_a),
    .in_tag (tag_a),
    .entry  (rom_data),
    .modw   (mod_cap),
    .per    (per_cap),
    .out_vld(scl_vld),
    .out_tag(scl_tag),
    .out_val(scl_val)
  );

  // collect results, publish all phases at once
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_o <= 1'b0;
      for (int p = 0; p < NPH; p++) cmp_q[p] <= per_i >> 1;
    end else begin
      upd_o <= 1'b0;
      if (scl_vld) begin
        if (scl_tag == LAST_PH) begin
          for (int p = 0; p < NPH - 1; p++) cmp_q[p] <= res[p];
          cmp_q[NPH-1] <= scl_val;
          upd_o        <= 1'b1;
        end else begin
          res[scl_tag] <= scl_val;
        end
      end
    end
  end

  assign cmp_a_o = cmp_q[0];
  assign cmp_b_o = cmp_q[1];
  assign cmp_c_o = cmp_q[2];
endmodule

// File: rtl/spwm_seq_chk.sv
module spwm_seq_chk #(
  parameter int PW = 16,
  parameter int MW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          upd_o,
  input logic [PW-1:0] cmp_a_o,
  input logic [PW-1:0] cmp_b_o,
  input logic [PW-1:0] cmp_c_o,
  input logic [MW-1:0] mod_cap
);
  localparam logic [MW-1:0] ONE = MW'(1) << (MW - 1);

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);                                          // R7
  AST_UPD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> $past(accept, 6));                                // R7
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!upd_o && !$past(rst)) |-> ($stable(cmp_a_o) && $stable(cmp_b_o) && $stable(cmp_c_o))); // R7
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);                                        // R8
  AST_MOD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    mod_cap <= ONE);                                            // R4
endmodule

bind spwm_seq spwm_seq_chk #(.PW(PW), .MW(MW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .accept (accept),
  .upd_o  (upd_o),
  .cmp_a_o(cmp_a_o),
  .cmp_b_o(cmp_b_o),
  .cmp_c_o(cmp_c_o),
  .mod_cap(mod_cap)
);

// File: tb/test_spwm_seq.sv
module test_spwm_seq;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        zero_evt = 1'b0;
  logic [15:0] per_i = 16'd1999;
  logic [15:0] mod_i = 16'd32768;
  logic [8:0]  ofs_a_i = 9'd0, ofs_b_i = 9'd167, ofs_c_i = 9'd333;
  logic [15:0] cmp_a_o, cmp_b_o, cmp_c_o;
  logic        upd_o;

  int checks = 0, errors = 0;
  longint cyc = 0;
  int bidx [3];
  bit done = 0;

  typedef struct {
    longint a, b, c;
    longint at;
    string  req;
  } item_t;
  item_t sb [$];

  spwm_seq i_spwm_seq (.*);

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint tbl(int i);
    real ang, v;
    longint c;
    ang = 2.0 * 3.14159265358979 * real'(i) / 500.0;
    v   = 32767.5 * (1.0 + $sin(ang)) + 0.5;
    c   = longint'($rtoi(v));
    if (c > 65535) c = 65535;
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint next_word(int p, longint per, longint m);
    int w;
    longint e;
    w = (bidx[p] >= 500) ? 0 : bidx[p];
    e = (per * m * tbl(w)) >>> 31;
    if (e > per) e = per;
    bidx[p] = w + 1;
    return e;
  endfunction

  // driver: push expected item, pulse the zero strobe
  task automatic fire(string req, int hold = 1, bit chg = 0);
    item_t it;
    longint m;
    @(negedge clk);
    m = (mod_i > 16'd32768) ? 32768 : longint'(mod_i);
    it.a = next_word(0, longint'(per_i), m);
    it.b = next_word(1, longint'(per_i), m);
    it.c = next_word(2, longint'(per_i), m);
    it.at = cyc + 6;
    it.req = req;
    sb.push_back(it);
    zero_evt = 1'b1;
    repeat (hold) @(negedge clk);
    zero_evt = 1'b0;
    if (chg) begin
      per_i = 16'd777;
      mod_i = 16'd5000;
    end
    repeat (5) @(negedge clk);
  endtask

  // monitor: compare results as they appear
  always @(negedge clk) begin
    if (!rst && upd_o) begin
      if (sb.size() == 0) begin
        chk(0, "R7", "spurious update", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(cyc == it.at, "R7", "update cycle", cyc, it.at);
        chk(longint'(cmp_a_o) == it.a, it.req, "phase A", cmp_a_o, it.a);
        chk(longint'(cmp_b_o) == it.b, it.req, "phase B", cmp_b_o, it.b);
        chk(longint'(cmp_c_o) == it.c, it.req, "phase C", cmp_c_o, it.c);
      end
    end
  end

  task automatic do_reset(int oa, int ob, int oc);
    @(negedge clk);
    rst = 1'b1;
    ofs_a_i = 9'(oa); ofs_b_i = 9'(ob); ofs_c_i = 9'(oc);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bidx[0] = oa; bidx[1] = ob; bidx[2] = oc;
    @(negedge clk);
    chk(cmp_a_o == per_i >> 1, "R1", "reset cmp A", cmp_a_o, per_i >> 1);
    chk(cmp_b_o == per_i >> 1, "R1", "reset cmp B", cmp_b_o, per_i >> 1);
    chk(cmp_c_o == per_i >> 1, "R1", "reset cmp C", cmp_c_o, per_i >> 1);
    chk(upd_o == 1'b0, "R1", "reset upd", upd_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1, R6: reset state and 120 degree offsets
    do_reset(0, 167, 333);
    // R2, R3: full depth sweep
    for (int k = 0; k < 12; k++) fire("R2");
    // R3: half depth
    mod_i = 16'd16384;
    for (int k = 0; k < 6; k++) fire("R3");
    // R4: depth above unity clamps
    mod_i = 16'd40000;
    for (int k = 0; k < 4; k++) fire("R4");
    mod_i = 16'd32768;
    // R8: held strobe advances once
    fire("R8", 3);
    fire("R8");
    fire("R8", 2);
    fire("R8");
    // R9: operands change after acceptance
    fire("R9", 1, 1);
    fire("R9");
    per_i = 16'd1999; mod_i = 16'd32768;
    // R5: walk beyond the wrap point
    for (int k = 0; k < 520; k++) fire("R5");
    // R3: period extremes
    per_i = 16'd0;
    fire("R3");
    per_i = 16'd65535;
    for (int k = 0; k < 3; k++) fire("R3");
    // R5, R6: offsets at and past the wrap
    per_i = 16'd1000;
    do_reset(500, 10, 499);
    for (int k = 0; k < 3; k++) fire("R6");
    do_reset(511, 0, 250);
    fire("R5");
    fire("R5");
    repeat (12) @(negedge clk);
    chk(sb.size() == 0, "R7", "missing updates", sb.size(), 0);
    finish_run();
  end
endmodule